// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Generator for a Three-Phase Stack of H-Bridges

This block drives nine H-bridge modules: three phases, each built from three series-stacked bridges. For every phase it takes one signed reference word and compares it against three triangular carriers. The carriers share one programmable peak and are spaced a third of a carrier period apart. Each comparison drives one module of that phase. Because the three carriers are staggered, the three modules of a phase switch at different instants. The summed phase voltage therefore steps three times as often as any single module does.

The carriers are symmetric triangles from 16-bit up/down counters running between zero and the peak. Each reference is clamped to plus or minus the peak. It is captured into a shadow register only at the turning points of carrier 0, so a reference that changes mid-period cannot cut a pulse short. The output gives every module two leg commands using unipolar modulation. The positive leg follows the reference and the negative leg follows the inverted reference.

Top module: `pscpwm_gen`

## Requirements
- R1: A synchronous active-low reset drives every bridge state to 00, clears every shadow reference to zero and returns each carrier to its start point. All of these take effect at the first rising clock edge with `rst_n` low.
- R2: Each carrier is a triangle whose count runs 0, 1, …, P, P-1, …, 1, 0, 1, …. The period is 2P clocks, where P is `peak_i` (P ≥ 3, held constant outside reset). Carrier 0 leaves reset at count 0 and rising.
- R3: Carrier k (k = 0, 1, 2) leaves reset at triangle position floor(2P·k/3). A position below P+1 means count equal to the position, rising. A higher position means count 2P minus the position, falling. So module k of a phase switches floor(2P·k/3) clocks ahead of module 0.
- R4: Module m = 3·phase + k drives `bridge_o[2m+1:2m]`. Bit 0 (positive leg) is 1 when the shadow reference S is greater than carrier k. Bit 1 (negative leg) is 1 when -S is greater than carrier k. Both legs are never high together.
- R5: The reference of phase p is `ref_i[16p+15:16p]`, signed two's complement. It is copied into the shadow register only on a clock edge at which carrier 0 equals 0 or P. A reference change at any other time has no effect on the outputs until that point.
- R6: A reference above P is treated as P, and one below -P as -P. While the shadow value is P, bit 0 stays 1 for every carrier value. While it is -P, bit 1 stays 1. In neither case does a leg toggle.
- R7: A zero reference keeps both legs of all three modules of that phase at 0.
- R8: Each bridge state is registered. The state seen after a clock edge reflects the shadow value and carrier counts held just before that edge.
- R9: With a mid-range reference, during one carrier period each module's positive leg changes exactly twice. The positive legs of a phase change at six distinct clock cycles, which is three times the per-module rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| peak_i | input | 16 | Carrier peak P; one carrier period is 2P clocks |
| ref_i | input | 48 | Three signed 16-bit references, phase p at bits 16p+15:16p |
| bridge_o | output | 18 | Nine 2-bit bridge states, module m at bits 2m+1:2m (bit 0 positive leg, bit 1 negative leg) |

## Verification
The hardest case to reach from the ports is a reference that moves while carrier 0 is between its turning points. If the shadow register leaked such a change, the result would look like an ordinary valid level change. The random stimulus therefore rewrites references on arbitrary cycles, mostly away from the turning points. A cycle-exact model, which updates its shadow copy only at those points, then exposes any early take-over on the very next output. Interleaving and start offsets are checked in a separate way. A fixed mid-range reference is applied, and the measured edge times of the three modules in a phase must differ by exactly the expected carrier offsets.

// File: rtl/pscpwm_pkg.sv
// Package: shared types of the phase-shifted carrier PWM generator.
// Assumes nothing beyond SystemVerilog packed types.
package pscpwm_pkg;

    // Counting direction of a triangle carrier.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Two leg commands of one H-bridge; pos lands in bit 0.
    typedef struct packed {
        logic neg;
        logic pos;
    } bridge_t;

endpackage

// File: rtl/pscpwm_carrier.sv
// Module: one symmetric triangle carrier from an up/down counter.
// Counts 0..peak_i and back, period 2*peak_i clocks. On reset it starts at
// triangle position floor(2*peak_i*IDX/N_CAR), so carriers with different IDX
// are spread evenly over one period. Assumes peak_i is held during reset.
module pscpwm_carrier
    import pscpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CAR = 3,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] peak_i,
    output logic [CNT_W-1:0] car_o
);

    localparam int FW = CNT_W + 1;                  // width of a full-period position
    localparam int OW = FW + $clog2(N_CAR + 1);     // width of the offset product

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_init;
    dir_e             dir_q, dir_d, dir_init;
    logic [FW-1:0]    full_len;
    logic [OW-1:0]    off_prod, off_pos;
    logic [FW-1:0]    off_fw, mirror_fw;

    // Start position of this carrier, derived from the period and its index.
    always_comb begin
        full_len  = {peak_i, 1'b0};
        off_prod  = {{(OW-FW){1'b0}}, full_len} * OW'(IDX);
        off_pos   = off_prod / OW'(N_CAR);
        off_fw    = off_pos[FW-1:0];
        mirror_fw = full_len - off_fw;
        if (off_fw <= {1'b0, peak_i}) begin
            cnt_init = off_fw[CNT_W-1:0];
            dir_init = DIR_UP;
        end else begin
            cnt_init = mirror_fw[CNT_W-1:0];
            dir_init = DIR_DOWN;
        end
    end

    // Next count and direction: turn at the peak and at zero.
    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (peak_i == '0) begin
            cnt_d = '0;
            dir_d = DIR_UP;
        end else if (cnt_q > peak_i) begin
            cnt_d = peak_i - 1'b1;
            dir_d = DIR_DOWN;
        end else if (dir_q == DIR_UP) begin
            if (cnt_q == peak_i) begin
                cnt_d = peak_i - 1'b1;
                dir_d = DIR_DOWN;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
                dir_d = DIR_UP;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Counter register with synchronous reset to the start position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= cnt_init;
            dir_q <= dir_init;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign car_o = cnt_q;

    AST_CAR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= peak_i) || (peak_i != $past(peak_i)));                 // R2
    AST_TURN_AT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == DIR_UP && cnt_q == peak_i && peak_i != '0 && $stable(peak_i))
        |=> (dir_q == DIR_DOWN));                                          // R2

endmodule

// File: rtl/pscpwm_phase.sv
// Module: one phase, holding a clamped shadow reference and N_MOD bridge states.
// The reference is clamped to +/-peak_i and captured only when load_i is high.
// Each module compares the shadow against its own carrier (unipolar: the
// negative leg uses the inverted reference). Bridge states are registered.
module pscpwm_phase
    import pscpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REF_W = 16,
    parameter int N_MOD = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         peak_i,
    input  logic                     load_i,
    input  logic signed [REF_W-1:0]  ref_i,
    input  logic [N_MOD*CNT_W-1:0]   car_i,
    output logic [2*N_MOD-1:0]       state_o
);

    localparam int SW = CNT_W + 1;                           // shadow width
    localparam int XW = ((REF_W > SW) ? REF_W : SW) + 1;     // compare width
    localparam logic signed [XW-1:0] ZERO_X = '0;

    logic signed [XW-1:0] ref_x, pk_x, npk_x, clamp_x, sh_x, nsh_x;
    logic signed [SW-1:0] shadow_q;

    // Clamp the incoming reference to the carrier range.
    always_comb begin
        ref_x = {{(XW-REF_W){ref_i[REF_W-1]}}, ref_i};
        pk_x  = {{(XW-CNT_W){1'b0}}, peak_i};
        npk_x = -pk_x;
        if (ref_x > pk_x)       clamp_x = pk_x;
        else if (ref_x < npk_x) clamp_x = npk_x;
        else                    clamp_x = ref_x;
    end

    // Shadow register: take the clamped reference only at a carrier-0 turn.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (load_i) shadow_q <= clamp_x[SW-1:0];
    end

    assign sh_x  = {{(XW-SW){shadow_q[SW-1]}}, shadow_q};
    assign nsh_x = -sh_x;

    bridge_t state_q [N_MOD];

    for (genvar k = 0; k < N_MOD; k++) begin : g_mod
        logic signed [XW-1:0] car_x;
        bridge_t              nxt;

        // Leg decisions for this module; a full-scale shadow holds its leg.
        always_comb begin
            car_x   = {{(XW-CNT_W){1'b0}}, car_i[k*CNT_W +: CNT_W]};
            nxt.pos = (sh_x > car_x)  || ((sh_x > ZERO_X)  && (sh_x >= pk_x));
            nxt.neg = (nsh_x > car_x) || ((nsh_x > ZERO_X) && (nsh_x >= pk_x));
        end

        // Registered bridge state, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) state_q[k] <= '0;
            else        state_q[k] <= nxt;
        end

        assign state_o[2*k +: 2] = state_q[k];

        AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(state_q[k]));                                          // R4
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(shadow_q));                                     // R5
    AST_SHADOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> (sh_x <= $past(pk_x)) && (sh_x >= -$past(pk_x)));  // R6

endmodule

// File: rtl/pscpwm_gen.sv
// Module: top of the phase-shifted carrier PWM generator.
// N_CAR carriers spaced 1/N_CAR of a period drive N_MOD modules in each of
// N_PH phases; carrier 0 turning points gate reference capture in every phase.
// Assumes peak_i >= 3 and is changed only while rst_n is low.
module pscpwm_gen
    import pscpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REF_W = 16,
    parameter int N_PH  = 3,
    parameter int N_MOD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        peak_i,
    input  logic [N_PH*REF_W-1:0]   ref_i,
    output logic [2*N_PH*N_MOD-1:0] bridge_o
);

    localparam int STW = 2 * N_MOD;   // state bits per phase

    logic [N_MOD*CNT_W-1:0] car_bus;
    logic                   load_en;

    for (genvar k = 0; k < N_MOD; k++) begin : g_car
        pscpwm_carrier #(
            .CNT_W (CNT_W),
            .N_CAR (N_MOD),
            .IDX   (k)
        ) u_carrier (
            .clk    (clk),
            .rst_n  (rst_n),
            .peak_i (peak_i),
            .car_o  (car_bus[k*CNT_W +: CNT_W])
        );
    end

    // Capture window: carrier 0 at either turning point.
    assign load_en = (car_bus[CNT_W-1:0] == '0) || (car_bus[CNT_W-1:0] == peak_i);

    for (genvar p = 0; p < N_PH; p++) begin : g_ph
        pscpwm_phase #(
            .CNT_W (CNT_W),
            .REF_W (REF_W),
            .N_MOD (N_MOD)
        ) u_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .peak_i  (peak_i),
            .load_i  (load_en),
            .ref_i   (ref_i[p*REF_W +: REF_W]),
            .car_i   (car_bus),
            .state_o (bridge_o[p*STW +: STW])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $rose(rst_n) |-> (bridge_o == '0));                                 // R1

endmodule

// File: tb/pscpwm_gen_bench.sv
// Bench: cycle-exact position-based model, random plus directed references.
module pscpwm_gen_bench;

    localparam int CNT_W = 16;
    localparam int REF_W = 16;
    localparam int NP    = 3;
    localparam int NM    = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [CNT_W-1:0]       peak = 16'd30;
    logic [NP*REF_W-1:0]    ref_bus = '0;
    logic [2*NP*NM-1:0]     bridge;

    always #5 clk = ~clk;

    pscpwm_gen #(.CNT_W(CNT_W), .REF_W(REF_W), .N_PH(NP), .N_MOD(NM)) u_pscpwm_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .peak_i   (peak),
        .ref_i    (ref_bus),
        .bridge_o (bridge)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    wd = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string tag = "R1";

    int         m_pos [NM];
    int         m_sh  [NP];
    logic [1:0] m_exp [NP*NM];

    function automatic int tri_f(input int pos, input int pk);
        return (pos <= pk) ? pos : 2*pk - pos;
    endfunction

    function automatic int clamp_f(input int v, input int pk);
        if (v > pk)  return pk;
        if (v < -pk) return -pk;
        return v;
    endfunction

    function automatic logic [1:0] leg_f(input int sh, input int car, input int pk);
        logic lp, ln;
        lp = (sh > car) || (sh > 0 && sh >= pk);
        ln = (-sh > car) || (-sh > 0 && -sh >= pk);
        return {ln, lp};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model, advanced on each rising edge (R2, R3, R5, R6, R8).
    always @(posedge clk) begin
        int pk;
        int c0;
        pk = int'(peak);
        if (!rst_n) begin
            for (int k = 0; k < NM; k++) m_pos[k] = (2*pk*k) / NM;
            for (int p = 0; p < NP; p++) m_sh[p] = 0;
            for (int m = 0; m < NP*NM; m++) m_exp[m] = 2'b00;
        end else begin
            c0 = tri_f(m_pos[0], pk);
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < NM; k++)
                    m_exp[p*NM+k] = leg_f(m_sh[p], tri_f(m_pos[k], pk), pk);
            if (c0 == 0 || c0 == pk)
                for (int p = 0; p < NP; p++)
                    m_sh[p] = clamp_f(int'($signed(ref_bus[p*REF_W +: REF_W])), pk);
            for (int k = 0; k < NM; k++) m_pos[k] = (m_pos[k] + 1) % (2*pk);
        end
    end

    // Continuous comparison against the model, away from the active edge (R4, R8).
    always @(negedge clk) begin
        if (cmp_on && !finished)
            for (int m = 0; m < NP*NM; m++)
                check(bridge[2*m +: 2] == m_exp[m], tag, int'(bridge[2*m +: 2]), int'(m_exp[m]));
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected below 150000", wd);
            finish_run();
        end
    end

    task automatic do_reset(input int pk);
        @(negedge clk);
        rst_n = 1'b0;
        peak  = CNT_W'(pk);
        repeat (3) @(negedge clk);
        check(bridge == '0, "R1", int'(bridge), 0);
        rst_n = 1'b1;
    endtask

    task automatic set_ref(input int p, input int v);
        ref_bus[p*REF_W +: REF_W] = REF_W'(v);
    endtask

    task automatic run_random(input int pk, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if ($urandom_range(6, 0) == 0)
                set_ref(int'($urandom_range(NP-1, 0)), int'($urandom_range(2*pk, 0)) - pk);
        end
    endtask

    initial begin
        int pk;
        int dummy;
        logic [2*NP*NM-1:0] prev;
        int tog [NP*NM];
        int fall_t [NM];
        int any_chg;

        dummy = $urandom(32'd20517);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bridge == '0, "R1", int'(bridge), 0);   // R1 reset state
        cmp_on = 1'b1;
        rst_n  = 1'b1;

        // R7: zero references keep every leg low.
        tag = "R7";
        repeat (200) @(negedge clk);
        check(bridge == '0, "R7", int'(bridge), 0);

        // R4/R5/R8: random references changed on arbitrary cycles.
        tag = "R4/R5/R8";
        run_random(30, 3000);

        // R2/R3: other periods, including a short and a long one.
        tag = "R2/R3";
        do_reset(7);
        run_random(7, 800);
        do_reset(1000);
        run_random(1000, 8000);
        do_reset(3);
        run_random(3, 300);

        // R6: full-scale and out-of-range references hold their legs.
        tag = "R6";
        pk = 40;
        do_reset(pk);
        set_ref(0, pk);
        set_ref(1, -(pk + 77));
        set_ref(2, 32767);
        repeat (2*pk + 5) @(negedge clk);
        prev = bridge;
        for (int m = 0; m < NP*NM; m++) tog[m] = 0;
        for (int i = 0; i < 2*pk; i++) begin
            @(negedge clk);
            for (int m = 0; m < NP*NM; m++)
                if (bridge[2*m +: 2] != prev[2*m +: 2]) tog[m]++;
            prev = bridge;
        end
        for (int m = 0; m < NP*NM; m++) begin
            check(tog[m] == 0, "R6", tog[m], 0);
            check(bridge[2*m +: 2] == ((m / NM == 1) ? 2'b10 : 2'b01), "R6",
                  int'(bridge[2*m +: 2]), (m / NM == 1) ? 2 : 1);
        end

        // R9 and R3: mid-range reference, interleaved edges at known offsets.
        tag = "R9";
        pk = 30;
        do_reset(pk);
        set_ref(0, pk / 2);
        set_ref(1, 0);
        set_ref(2, 0);
        repeat (2*pk + 5) @(negedge clk);
        prev = bridge;
        for (int k = 0; k < NM; k++) begin
            tog[k] = 0;
            fall_t[k] = -1;
        end
        any_chg = 0;
        for (int i = 0; i < 2*pk; i++) begin
            bit chg;
            @(negedge clk);
            chg = 1'b0;
            for (int k = 0; k < NM; k++) begin
                if (bridge[2*k] != prev[2*k]) begin
                    tog[k]++;
                    chg = 1'b1;
                    if (prev[2*k] == 1'b1) fall_t[k] = i;
                end
            end
            if (chg) any_chg++;
            prev = bridge;
        end
        for (int k = 0; k < NM; k++)
            check(tog[k] == 2, "R9", tog[k], 2);
        check(any_chg == 6, "R9", any_chg, 6);
        for (int k = 1; k < NM; k++)   // R3: module k leads module 0 by its offset
            check(((fall_t[0] - fall_t[k] + 2*pk) % (2*pk)) == (2*pk*k) / NM, "R3",
                  (fall_t[0] - fall_t[k] + 2*pk) % (2*pk), (2*pk*k) / NM);

        // R5: a reference written just after a capture stays invisible until the next turn.
        tag = "R5";
        run_random(pk, 600);

        cmp_on = 1'b0;
        finish_run();
    end

endmodule